// File: doc/BRIEF.md
# Registered Memory Module Power Sequencer

This block sits on the system side of a registered DDR memory module. It drives the module's asynchronous register reset, the clock-enable line, the four command strobes, an enable for the module clock outputs and an enable for the address/control drivers. The module's input register forces all of its outputs low while its reset is low. The register also adds one cycle of latency to every command. Because of both facts, reset has to be ordered against CKE, the clocks and the bus drivers, and this sequencer enforces that order.

After power-up the sequencer keeps the module reset low until supplies are good and the clock has settled. It then waits out the PLL lock time and the SDRAM clock stabilisation time, with CKE low and a deselect on the bus. Next it releases reset and holds the bus still for the register activation time. Finally it raises a ready flag, which hands the module to the initialisation engine. On request it puts the module into self-refresh, in one of two variants chosen with the request: clocks stopped or clocks running. A later request brings the module back out. All waits are counted in reference-clock cycles, and the counts are set by parameters.

Top module: `rdimm_pwr_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are `dimm_reset_n`=0, `cke`=0, `clk_oe`=0, `bus_oe`=0, `init_ready`=0 and `req_err`=0, and all four command strobes are 1 (deselect).
- R2: `clk_oe` stays 0 until `pwr_good` is seen high, and rises in the cycle after that. Once `clk_stable` is high, `dimm_reset_n` remains 0 for exactly PLL_CYC + STAB_CYC cycles. `bus_oe` is 0 during the first PLL_CYC of those cycles and 1 during the last STAB_CYC.
- R3: While the bus is driven ahead of a reset release, and in the cycle in which `dimm_reset_n` rises, `cke`=0 and the bus carries deselect (`cs_n`=`ras_n`=`cas_n`=`we_n`=1).
- R4: After `dimm_reset_n` rises, `cke` stays 0 with deselect for exactly ACT_CYC cycles. Then `init_ready` rises together with `cke`=1, and `init_ready` is never 1 while `dimm_reset_n` or `cke` is 0.
- R5: `sr_enter_req` in the ready state yields, in the next cycle, one cycle of the self-refresh command (`cke`=0, `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1) with reset high. One further cycle of deselect with reset still high follows, to cover the module register latency.
- R6: Next, `dimm_reset_n` is 0 for ACT-independent INACT_CYC cycles while `clk_oe`=1 and `bus_oe`=1. After that `bus_oe` drops, and `clk_oe` drops only if `sr_clk_off` was 1 when the entry was requested.
- R7: `sr_exit_req` in self-refresh restarts the clock outputs when they were stopped. It then waits for `clk_stable` and PLL_CYC cycles, and gives one cycle with reset low, `bus_oe`=1 and deselect before reset rises (PLL_CYC+1 reset-low cycles from `clk_stable`). In the clocks-running variant, exactly one such cycle follows the request.
- R8: `clk_oe` is 0 only while `dimm_reset_n` is 0, and `bus_oe` is 0 only while `dimm_reset_n` is 0.
- R9: An exit request in the ready state, or an entry request in self-refresh, is rejected. `req_err` pulses high for exactly one cycle and the outputs are left unchanged.
- R10: Requests that arrive while any sequence is in progress are ignored. They raise no error, and they change neither the lengths of the phases nor the outputs.
- R11: When `pwr_good` is low at a clock edge, the next cycle shows the R1 output values, and power-up restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| pwr_good | input | 1 | Supplies are within range |
| clk_stable | input | 1 | System clock to the module has settled |
| sr_enter_req | input | 1 | Strobe: request self-refresh entry |
| sr_clk_off | input | 1 | With an entry request: 1 stops clocks in self-refresh |
| sr_exit_req | input | 1 | Strobe: request self-refresh exit |
| dimm_reset_n | output | 1 | Module register reset, active low |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| clk_oe | output | 1 | Enable for module clock outputs |
| bus_oe | output | 1 | Enable for address/control drivers |
| init_ready | output | 1 | Module ready for the initialisation or exit engine |
| req_err | output | 1 | One-cycle pulse on a rejected request |

## Verification
The assertions assume that the request strobes last one cycle, and that `clk_stable` is low whenever the bench has stopped the clock outputs. The power-loss property also relies on `pwr_good` being sampled once per edge, with no other input overriding it. The stimulus drives every strobe for exactly one cycle at a falling edge. It lowers `clk_stable` only while `clk_oe` is 0, and it drops `pwr_good` only in the ready state. Random entry modes, delays and stray requests are drawn inside these limits.

// File: rtl/rdimm_seq_pkg.sv
package rdimm_seq_pkg;

  typedef enum logic [3:0] {
    ST_PWRUP, ST_CLKON, ST_PLL, ST_STAB, ST_ACT, ST_READY,
    ST_SRCMD, ST_SRHOLD, ST_INACT, ST_SRIDLE, ST_XCLK, ST_XPLL, ST_XNOP
  } seq_state_e;

  typedef struct packed {
    logic reset_n;
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic clk_oe;
    logic bus_oe;
    logic ready;
  } pin_set_t;

  // All outputs quiet: reset asserted, CKE low, deselect, drivers off.
  localparam pin_set_t PINS_OFF = '{reset_n: 1'b0, cke: 1'b0, cs_n: 1'b1,
                                    ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                                    clk_oe: 1'b0, bus_oe: 1'b0, ready: 1'b0};

  function automatic pin_set_t pins_for(seq_state_e st, logic clk_off);
    pin_set_t p;
    p = PINS_OFF;
    case (st)
      ST_CLKON, ST_PLL, ST_XCLK, ST_XPLL: p.clk_oe = 1'b1;
      ST_STAB, ST_XNOP, ST_INACT: begin
        p.clk_oe = 1'b1;
        p.bus_oe = 1'b1;
      end
      ST_ACT, ST_SRHOLD: begin
        p.reset_n = 1'b1;
        p.clk_oe  = 1'b1;
        p.bus_oe  = 1'b1;
      end
      ST_READY: begin
        p.reset_n = 1'b1;
        p.cke     = 1'b1;
        p.clk_oe  = 1'b1;
        p.bus_oe  = 1'b1;
        p.ready   = 1'b1;
      end
      ST_SRCMD: begin
        p.reset_n = 1'b1;
        p.clk_oe  = 1'b1;
        p.bus_oe  = 1'b1;
        p.cs_n    = 1'b0;
        p.ras_n   = 1'b0;
        p.cas_n   = 1'b0;
      end
      ST_SRIDLE: p.clk_oe = ~clk_off;
      default: p = PINS_OFF;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/rdimm_rst_sync.sv
module rdimm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rdimm_wait_timer.sv
module rdimm_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;
  logic         cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load | ~expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= load ? load_val : cnt_q - 1'b1;
  end
endmodule

// File: rtl/rdimm_pin_reg.sv
module rdimm_pin_reg
  import rdimm_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_set_t pins_d,
  input  logic     err_d,
  output pin_set_t pins_q,
  output logic     err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= PINS_OFF;
      err_q  <= 1'b0;
    end else begin
      pins_q <= pins_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/rdimm_pwr_seq.sv
module rdimm_pwr_seq
  import rdimm_seq_pkg::*;
#(
  parameter int PLL_CYC   = 10000,
  parameter int STAB_CYC  = 20000,
  parameter int ACT_CYC   = 64,
  parameter int INACT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic clk_stable,
  input  logic sr_enter_req,
  input  logic sr_clk_off,
  input  logic sr_exit_req,
  output logic dimm_reset_n,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic clk_oe,
  output logic bus_oe,
  output logic init_ready,
  output logic req_err
);
  localparam int MAX_AB = (PLL_CYC > STAB_CYC) ? PLL_CYC : STAB_CYC;
  localparam int MAX_CD = (ACT_CYC > INACT_CYC) ? ACT_CYC : INACT_CYC;
  localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = (MAX_C < 2) ? 1 : $clog2(MAX_C);
  localparam logic [CW-1:0] LD_PLL   = CW'(PLL_CYC - 1);
  localparam logic [CW-1:0] LD_STAB  = CW'(STAB_CYC - 1);
  localparam logic [CW-1:0] LD_ACT   = CW'(ACT_CYC - 1);
  localparam logic [CW-1:0] LD_INACT = CW'(INACT_CYC - 1);

  logic       srst_n;
  seq_state_e state_q, state_d;
  logic       mode_q, mode_d;
  logic       err_d;
  logic       tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  pin_set_t   pins_d, pins_q;

  rdimm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(srst_n)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    err_d   = 1'b0;
    case (state_q)
      ST_PWRUP:  if (pwr_good)   state_d = ST_CLKON;
      ST_CLKON:  if (clk_stable) state_d = ST_PLL;
      ST_PLL:    if (tmr_done)   state_d = ST_STAB;
      ST_STAB:   if (tmr_done)   state_d = ST_ACT;
      ST_ACT:    if (tmr_done)   state_d = ST_READY;
      ST_READY: begin
        if (sr_enter_req) begin
          state_d = ST_SRCMD;
          mode_d  = sr_clk_off;
        end else if (sr_exit_req) begin
          err_d = 1'b1;
        end
      end
      ST_SRCMD:  state_d = ST_SRHOLD;
      ST_SRHOLD: state_d = ST_INACT;
      ST_INACT:  if (tmr_done) state_d = ST_SRIDLE;
      ST_SRIDLE: begin
        if (sr_exit_req)       state_d = mode_q ? ST_XCLK : ST_XNOP;
        else if (sr_enter_req) err_d   = 1'b1;
      end
      ST_XCLK:   if (clk_stable) state_d = ST_XPLL;
      ST_XPLL:   if (tmr_done)   state_d = ST_XNOP;
      ST_XNOP:   state_d = ST_ACT;
      default:   state_d = ST_PWRUP;
    endcase
    if (!pwr_good) begin
      state_d = ST_PWRUP;
      err_d   = 1'b0;
    end
  end

  // Timer load on entry into a timed phase
  always_comb begin
    tmr_load = (state_d != state_q);
    case (state_d)
      ST_PLL, ST_XPLL: tmr_val = LD_PLL;
      ST_STAB:         tmr_val = LD_STAB;
      ST_ACT:          tmr_val = LD_ACT;
      ST_INACT:        tmr_val = LD_INACT;
      default:         tmr_val = '0;
    endcase
  end

  rdimm_wait_timer #(.W(CW)) u_tmr (
    .clk(clk), .rst_n(srst_n), .load(tmr_load),
    .load_val(tmr_val), .expired(tmr_done)
  );

  // State registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_PWRUP;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
    end
  end

  assign pins_d = pins_for(state_d, mode_d);

  rdimm_pin_reg u_pins (
    .clk(clk), .rst_n(srst_n), .pins_d(pins_d), .err_d(err_d),
    .pins_q(pins_q), .err_q(req_err)
  );

  assign dimm_reset_n = pins_q.reset_n;
  assign cke          = pins_q.cke;
  assign cs_n         = pins_q.cs_n;
  assign ras_n        = pins_q.ras_n;
  assign cas_n        = pins_q.cas_n;
  assign we_n         = pins_q.we_n;
  assign clk_oe       = pins_q.clk_oe;
  assign bus_oe       = pins_q.bus_oe;
  assign init_ready   = pins_q.ready;
endmodule

// File: rtl/rdimm_pwr_seq_chk.sv
module rdimm_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic dimm_reset_n,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic clk_oe,
  input logic bus_oe,
  input logic init_ready,
  input logic req_err
);
  p_clk_off_reset_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_oe |-> !dimm_reset_n);

  p_bus_off_reset_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> !dimm_reset_n);

  p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> !req_err);

  p_ready_levels_r4: assert property (@(posedge clk) disable iff (!rst_n)
    init_ready |-> (cke && dimm_reset_n));

  p_release_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dimm_reset_n) |-> (!cke && cs_n && ras_n && cas_n && we_n));

  p_sr_cmd_then_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !cs_n && !ras_n && !cas_n && we_n && pwr_good)
      |=> (cs_n && dimm_reset_n && !cke));

  p_power_loss_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!dimm_reset_n && !clk_oe && !bus_oe && !init_ready));
endmodule

bind rdimm_pwr_seq rdimm_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
  .dimm_reset_n(dimm_reset_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .clk_oe(clk_oe), .bus_oe(bus_oe),
  .init_ready(init_ready), .req_err(req_err)
);

// File: tb/sim_rdimm_pwr_seq.sv
`timescale 1ns/1ps
module sim_rdimm_pwr_seq;
  localparam int N_PLL   = 12;
  localparam int N_STAB  = 20;
  localparam int N_ACT   = 5;
  localparam int N_INACT = 7;

  logic clk = 1'b0;
  logic rst_n, pwr_good, clk_stable, sr_enter_req, sr_clk_off, sr_exit_req;
  logic dimm_reset_n, cke, cs_n, ras_n, cas_n, we_n, clk_oe, bus_oe, init_ready, req_err;

  int n_chk = 0;
  int n_fail = 0;
  int viol_r8 = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rdimm_pwr_seq #(.PLL_CYC(N_PLL), .STAB_CYC(N_STAB), .ACT_CYC(N_ACT),
                  .INACT_CYC(N_INACT)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .clk_stable(clk_stable),
    .sr_enter_req(sr_enter_req), .sr_clk_off(sr_clk_off), .sr_exit_req(sr_exit_req),
    .dimm_reset_n(dimm_reset_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .clk_oe(clk_oe), .bus_oe(bus_oe),
    .init_ready(init_ready), .req_err(req_err)
  );

  function automatic int exp_pwrup_low();
    return N_PLL + N_STAB;
  endfunction
  function automatic int exp_exit_low(bit off);
    return off ? N_PLL + 1 : 1;
  endfunction
  function automatic bit exp_idle_clk(bit off);
    return ~off;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // R8 monitor over the whole run
  always @(negedge clk)
    if (rst_n && (!clk_oe || !bus_oe) && dimm_reset_n) viol_r8++;

  task automatic power_up();
    repeat (3) @(negedge clk);
    check(clk_oe == 1'b0, "R2 clk_oe before pwr_good", clk_oe, 0);
    pwr_good = 1'b1;
    @(negedge clk);
    check(clk_oe && !dimm_reset_n && !bus_oe, "R2 clocks on after pwr_good",
          {clk_oe, dimm_reset_n, bus_oe}, 3'b100);
    repeat ($urandom % 4) @(negedge clk);
    clk_stable = 1'b1;
    @(negedge clk);
    begin
      int k = 0;
      bit b_pll = 1'b1, b_stab = 1'b0, quiet = 1'b1;
      while (!dimm_reset_n && k < 1000) begin
        if (k == N_PLL - 1) b_pll = bus_oe;
        if (k == N_PLL) b_stab = bus_oe;
        if (k >= N_PLL && (cke || !cs_n || !ras_n || !cas_n || !we_n)) quiet = 1'b0;
        k++;
        @(negedge clk);
      end
      check(k == exp_pwrup_low(), "R2 reset-low length", k, exp_pwrup_low());
      check(!b_pll && b_stab, "R2 bus_oe phase split", {b_pll, b_stab}, 2'b01);
      check(quiet, "R3 deselect with CKE low before release", quiet, 1);
      check(!cke && cs_n && ras_n && cas_n && we_n, "R3 release cycle quiet",
            {cke, cs_n, ras_n, cas_n, we_n}, 5'b01111);
    end
    act_phase(1'b0);
  endtask

  // Counts the activation phase, optionally injecting a stray request (R10)
  task automatic act_phase(input bit inject);
    int k = 0;
    int inj = $urandom % N_ACT;
    bit bad = 1'b0;
    while (!init_ready && k < 1000) begin
      if (cke || req_err || !dimm_reset_n) bad = 1'b1;
      if (inject && k == inj) begin
        if ($urandom % 2) sr_enter_req = 1'b1; else sr_exit_req = 1'b1;
      end else begin
        sr_enter_req = 1'b0;
        sr_exit_req  = 1'b0;
      end
      k++;
      @(negedge clk);
    end
    sr_enter_req = 1'b0;
    sr_exit_req  = 1'b0;
    check(k == N_ACT, "R4 activation length", k, N_ACT);
    check(!bad, "R10 activation phase unaffected", bad, 0);
    check(cke && dimm_reset_n && !req_err, "R4 ready levels",
          {cke, dimm_reset_n, req_err}, 3'b110);
  endtask

  task automatic reject_in_ready();
    sr_exit_req = 1'b1;
    @(negedge clk);
    sr_exit_req = 1'b0;
    check(req_err && init_ready && cke, "R9 exit in ready rejected",
          {req_err, init_ready, cke}, 3'b111);
    @(negedge clk);
    check(!req_err && init_ready, "R9 error is one cycle", req_err, 0);
  endtask

  task automatic enter_sr(input bit off);
    sr_clk_off   = off;
    sr_enter_req = 1'b1;
    @(negedge clk);
    sr_enter_req = 1'b0;
    check(!cke && !cs_n && !ras_n && !cas_n && we_n && dimm_reset_n,
          "R5 self-refresh command", {cke, cs_n, ras_n, cas_n, we_n, dimm_reset_n},
          6'b000011);
    @(negedge clk);
    check(!cke && cs_n && dimm_reset_n, "R5 latency cycle",
          {cke, cs_n, dimm_reset_n}, 3'b011);
    @(negedge clk);
    begin
      int k = 0;
      int inj = $urandom % N_INACT;
      bit bad = 1'b0;
      while (bus_oe && k < 1000) begin
        if (dimm_reset_n || !clk_oe || req_err || cke) bad = 1'b1;
        if (k == inj) begin
          if ($urandom % 2) sr_enter_req = 1'b1; else sr_exit_req = 1'b1;
        end else begin
          sr_enter_req = 1'b0;
          sr_exit_req  = 1'b0;
        end
        k++;
        @(negedge clk);
      end
      sr_enter_req = 1'b0;
      sr_exit_req  = 1'b0;
      check(k == N_INACT, "R6 deactivate length", k, N_INACT);
      check(!bad, "R10 deactivate phase unaffected", bad, 0);
      check(clk_oe == exp_idle_clk(off) && !dimm_reset_n && !req_err,
            "R6 idle clock state", clk_oe, exp_idle_clk(off));
    end
    if (off) clk_stable = 1'b0;
  endtask

  task automatic reject_in_sr(input bit off);
    sr_enter_req = 1'b1;
    @(negedge clk);
    sr_enter_req = 1'b0;
    check(req_err && !bus_oe && clk_oe == exp_idle_clk(off), "R9 entry in self-refresh rejected",
          {req_err, bus_oe, clk_oe}, {2'b10, exp_idle_clk(off)});
    @(negedge clk);
    check(!req_err, "R9 error is one cycle (sr)", req_err, 0);
  endtask

  task automatic exit_sr(input bit off);
    sr_exit_req = 1'b1;
    @(negedge clk);
    sr_exit_req = 1'b0;
    if (off) begin
      check(clk_oe && !dimm_reset_n && !bus_oe, "R7 clocks restarted",
            {clk_oe, dimm_reset_n, bus_oe}, 3'b100);
      repeat (1 + $urandom % 3) @(negedge clk);
      check(!dimm_reset_n, "R7 waits for clk_stable", dimm_reset_n, 0);
      clk_stable = 1'b1;
      @(negedge clk);
    end
    begin
      int k = 0;
      bit b_first = 1'b0, b_last = 1'b0;
      while (!dimm_reset_n && k < 1000) begin
        if (k == 0) b_first = bus_oe;
        b_last = bus_oe && !cke && cs_n;
        k++;
        @(negedge clk);
      end
      check(k == exp_exit_low(off), "R7 exit reset-low length", k, exp_exit_low(off));
      check(b_last && (b_first == !off), "R7 bus driven before release",
            {b_first, b_last}, {!off, 1'b1});
    end
    act_phase(1'b1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pwr_good = 1'b0; clk_stable = 1'b0;
    sr_enter_req = 1'b0; sr_clk_off = 1'b0; sr_exit_req = 1'b0;
    repeat (3) @(negedge clk);
    check(!dimm_reset_n && !cke && !clk_oe && !bus_oe && !init_ready && !req_err &&
          cs_n && ras_n && cas_n && we_n, "R1 reset state",
          {dimm_reset_n, cke, clk_oe, bus_oe, init_ready, req_err}, 0);
    rst_n = 1'b1;
    power_up();
    reject_in_ready();

    // directed: both variants, then random mix
    enter_sr(1'b1); reject_in_sr(1'b1); exit_sr(1'b1);
    enter_sr(1'b0); reject_in_sr(1'b0); exit_sr(1'b0);
    for (int it = 0; it < 12; it++) begin
      bit off = $urandom % 2;
      repeat ($urandom % 5) @(negedge clk);
      if ($urandom % 3 == 0) reject_in_ready();
      enter_sr(off);
      repeat ($urandom % 4) @(negedge clk);
      if ($urandom % 2) reject_in_sr(off);
      exit_sr(off);
    end

    // power loss from ready
    pwr_good = 1'b0;
    clk_stable = 1'b0;
    @(negedge clk);
    check(!dimm_reset_n && !clk_oe && !bus_oe && !init_ready && !cke,
          "R11 power loss", {dimm_reset_n, clk_oe, bus_oe, init_ready}, 0);
    power_up();

    check(viol_r8 == 0, "R8 enables off only with reset low", viol_r8, 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule